// File: doc/BRIEF.md
# Dual-Lane Serializer with Fast/Interleaved Path Router

The block takes parallel bytes from a synchronous-transfer or cell source and sends each one out as two parallel bit lanes: an even lane holding the even-numbered bits and an odd lane holding the odd-numbered bits. One bit of each lane leaves per clock, so an 8-bit byte takes four clocks. The two lanes are merged into a single stream of bit pairs. Each byte of that stream is steered whole onto one of two outputs, the fast path or the interleaved path.

The path for a byte is chosen when the byte is accepted. A mode input picks where the choice comes from. It is either a per-byte address-style select that travels with the data, or a static configuration input. The choice then holds until the byte's last pair has gone out.

The receive half does the reverse. It merges pairs arriving on either path into one stream, splits each pair back into its even and odd lanes, and rebuilds the byte. It also reports which path delivered the first pair of that byte.

Top module: `dual_lane_chan_router`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `tx_fast_vld`, `tx_intl_vld` and `rx_byte_vld` are 0 and `tx_ready` is 1.
- R2: An accepted byte D appears on its path over exactly four consecutive cycles, starting the cycle after acceptance. In step i (0..3) the pair output is {D[2i+1], D[2i]}: pair bit 0 is the even lane and pair bit 1 is the odd lane, so bit 0 of the byte goes first.
- R3: With `cfg_mode`=0 the byte's path is `tx_addr_sel` sampled at acceptance. With `cfg_mode`=1 it is `cfg_path`. In both cases 0 selects the fast path and 1 the interleaved path.
- R4: Changes to `tx_addr_sel`, `cfg_path` or `cfg_mode` while a byte is being sent have no effect on that byte's path or bits.
- R5: A path's valid strobe is high only while that path carries a pair of an accepted byte, and the two transmit strobes are never high together. The pair output of a path whose strobe is low is 0.
- R6: `tx_ready` is 1 when no byte is in flight and during the last pair of a byte. A byte accepted in that last-pair cycle begins on the very next cycle, with no idle gap.
- R7: On receive, after four accepted pairs, `rx_byte_vld` pulses for one cycle on the following cycle. `rx_byte` then holds the byte rebuilt with the same pair-to-bit mapping as R2.
- R8: When `rx_fast_vld` and `rx_intl_vld` are both 1 in a cycle, only the fast pair is taken and the interleaved pair is dropped.
- R9: With each rebuilt byte, `rx_path` gives the path of its first pair (0 fast, 1 interleaved).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_addr_sel | input | 1 | Per-byte path select (0 fast, 1 interleaved) |
| cfg_mode | input | 1 | Select source: 0 per-byte input, 1 configuration |
| cfg_path | input | 1 | Configured path (0 fast, 1 interleaved) |
| tx_ready | output | 1 | Byte is accepted this cycle if tx_valid |
| tx_fast_pair | output | 2 | Fast path pair {odd, even} |
| tx_fast_vld | output | 1 | Fast path pair valid |
| tx_intl_pair | output | 2 | Interleaved path pair {odd, even} |
| tx_intl_vld | output | 1 | Interleaved path pair valid |
| rx_fast_pair | input | 2 | Received fast pair {odd, even} |
| rx_fast_vld | input | 1 | Received fast pair valid |
| rx_intl_pair | input | 2 | Received interleaved pair {odd, even} |
| rx_intl_vld | input | 1 | Received interleaved pair valid |
| rx_byte | output | 8 | Rebuilt byte |
| rx_byte_vld | output | 1 | One-cycle strobe for rx_byte |
| rx_path | output | 1 | Path of the rebuilt byte's first pair |

## Verification
Two events can fall in one transmit cycle: the last pair of a byte goes out while the next byte is loaded, possibly onto the other path. The bench provokes this by holding `tx_valid` high across several bytes with alternating selects. A behavioural model then judges every cycle for an unbroken pair sequence and a clean hand-over of the strobes. On receive, the two paths can both present a pair in one cycle. The bench drives that case with different data on each path and expects a byte built only from the fast pairs.

// File: rtl/dlcr_pkg.sv
// Package: shared types for the dual-lane router.
// Assumes: path encoding 0 = fast, 1 = interleaved, used on every port.
package dlcr_pkg;
    typedef enum logic {
        PATH_FAST = 1'b0,
        PATH_INTL = 1'b1
    } path_e;
endpackage

// File: rtl/dlcr_lane_ser.sv
// Module: dlcr_lane_ser
// Splits a loaded byte into an even-bit lane and an odd-bit lane and
// shifts one bit of each lane out per clock, lowest index first.
// Assumes: DATA_W is even and at least 4; load is only raised when ready.
module dlcr_lane_ser #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              active,
    output logic              last,
    output logic              even_bit,
    output logic              odd_bit
);
    localparam int LANE_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(LANE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LANE_W - 1);

    logic [LANE_W-1:0] ev_init, od_init;
    logic [LANE_W-1:0] ev_q, od_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              act_q;

    // Route even-indexed bits to lane 0 and odd-indexed bits to lane 1.
    for (genvar g = 0; g < LANE_W; g++) begin : g_split
        assign ev_init[g] = data[2*g];
        assign od_init[g] = data[2*g+1];
    end

    // Load a new byte, or shift both lanes one step and count the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            ev_q  <= '0;
            od_q  <= '0;
        end else if (load) begin
            act_q <= 1'b1;
            cnt_q <= '0;
            ev_q  <= ev_init;
            od_q  <= od_init;
        end else if (act_q) begin
            ev_q  <= ev_q >> 1;
            od_q  <= od_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
                act_q <= 1'b0;
            end
        end
    end

    assign active   = act_q;
    assign last     = act_q && (cnt_q == LAST_IDX);
    assign even_bit = ev_q[0];
    assign odd_bit  = od_q[0];

    // R6: a new byte is never loaded over one still in flight.
    a_r6_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!act_q || last));

    // R2: a byte not at its last step keeps sending on the next cycle.
    a_r2_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !last && !load) |=> act_q);

    // R2: a load always leads to an active lane on the next cycle.
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (act_q && cnt_q == '0));
endmodule

// File: rtl/dlcr_path_steer.sv
// Module: dlcr_path_steer
// Latches the path choice of each byte when it is loaded and steers the
// merged {odd, even} pair onto the fast or interleaved output.
// Assumes: active and the lane bits come from dlcr_lane_ser.
module dlcr_path_steer
    import dlcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       addr_sel,
    input  logic       mode,
    input  logic       cfg_path,
    input  logic       active,
    input  logic       even_bit,
    input  logic       odd_bit,
    output logic [1:0] fast_pair,
    output logic       fast_vld,
    output logic [1:0] intl_pair,
    output logic       intl_vld
);
    path_e path_q;
    path_e path_new;
    logic [1:0] merged;

    // Pick the selector source named by the mode input.
    always_comb begin
        path_new = mode ? path_e'(cfg_path) : path_e'(addr_sel);
    end

    // Hold the path of the byte in flight; change it only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= PATH_FAST;
        end else if (load) begin
            path_q <= path_new;
        end
    end

    // Merge both lanes into one pair and steer it to the chosen path.
    always_comb begin
        merged    = {odd_bit, even_bit};
        fast_vld  = active && (path_q == PATH_FAST);
        intl_vld  = active && (path_q == PATH_INTL);
        fast_pair = fast_vld ? merged : 2'b00;
        intl_pair = intl_vld ? merged : 2'b00;
    end

    // R5: the two path strobes are never raised together.
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(fast_vld && intl_vld));

    // R4: a byte on the fast path does not move to the other path mid-byte.
    a_r4_fast_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_vld && !load) |=> !intl_vld);

    // R4: a byte on the interleaved path does not move mid-byte.
    a_r4_intl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (intl_vld && !load) |=> !fast_vld);
endmodule

// File: rtl/dlcr_lane_deser.sv
// Module: dlcr_lane_deser
// Merges pairs from the two receive paths (fast wins a tie), splits them
// into even and odd lanes, and rebuilds a byte after DATA_W/2 pairs.
// Assumes: DATA_W is even and at least 4.
module dlcr_lane_deser
    import dlcr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fast_pair,
    input  logic              fast_vld,
    input  logic [1:0]        intl_pair,
    input  logic              intl_vld,
    output logic [DATA_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              byte_path
);
    localparam int LANE_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(LANE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LANE_W - 1);

    logic [1:0]        pair_sel;
    logic              take;
    path_e             src;
    logic [LANE_W-1:0] ev_q, od_q, ev_nx, od_nx;
    logic [DATA_W-1:0] built;
    logic [CNT_W-1:0]  cnt_q;
    path_e             first_q;
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    path_e             bpath_q;

    // Merge the two paths into one pair stream; fast has priority.
    always_comb begin
        take     = fast_vld || intl_vld;
        pair_sel = fast_vld ? fast_pair : intl_pair;
        src      = fast_vld ? PATH_FAST : PATH_INTL;
        ev_nx    = {pair_sel[0], ev_q[LANE_W-1:1]};
        od_nx    = {pair_sel[1], od_q[LANE_W-1:1]};
    end

    // Interleave the two lanes back into byte order.
    for (genvar g = 0; g < LANE_W; g++) begin : g_join
        assign built[2*g]   = ev_nx[g];
        assign built[2*g+1] = od_nx[g];
    end

    // Collect pairs, remember the first path, and emit a finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q    <= '0;
            od_q    <= '0;
            cnt_q   <= '0;
            first_q <= PATH_FAST;
            byte_q  <= '0;
            vld_q   <= 1'b0;
            bpath_q <= PATH_FAST;
        end else begin
            vld_q <= 1'b0;
            if (take) begin
                ev_q <= ev_nx;
                od_q <= od_nx;
                if (cnt_q == '0) begin
                    first_q <= src;
                end
                if (cnt_q == LAST_IDX) begin
                    cnt_q   <= '0;
                    byte_q  <= built;
                    vld_q   <= 1'b1;
                    bpath_q <= first_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign byte_out  = byte_q;
    assign byte_vld  = vld_q;
    assign byte_path = bpath_q;

    // R7: a rebuilt byte is always preceded by an accepted pair.
    a_r7_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(take));

    // R7: the byte strobe lasts a single cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/dual_lane_chan_router.sv
// Module: dual_lane_chan_router (top)
// Transmit: even/odd lane serialiser plus per-byte path steering.
// Receive: path merge, lane split and byte reassembly.
// Assumes: DATA_W is even and at least 4; one clock domain.
module dual_lane_chan_router #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_addr_sel,
    input  logic              cfg_mode,
    input  logic              cfg_path,
    output logic              tx_ready,
    output logic [1:0]        tx_fast_pair,
    output logic              tx_fast_vld,
    output logic [1:0]        tx_intl_pair,
    output logic              tx_intl_vld,
    input  logic [1:0]        rx_fast_pair,
    input  logic              rx_fast_vld,
    input  logic [1:0]        rx_intl_pair,
    input  logic              rx_intl_vld,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_byte_vld,
    output logic              rx_path
);
    logic load, active, last, even_bit, odd_bit;

    // Accept a byte when idle or on the last pair of the current one.
    always_comb begin
        tx_ready = !active || last;
        load     = tx_valid && tx_ready;
    end

    dlcr_lane_ser #(.DATA_W(DATA_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .data     (tx_data),
        .active   (active),
        .last     (last),
        .even_bit (even_bit),
        .odd_bit  (odd_bit)
    );

    dlcr_path_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .addr_sel  (tx_addr_sel),
        .mode      (cfg_mode),
        .cfg_path  (cfg_path),
        .active    (active),
        .even_bit  (even_bit),
        .odd_bit   (odd_bit),
        .fast_pair (tx_fast_pair),
        .fast_vld  (tx_fast_vld),
        .intl_pair (tx_intl_pair),
        .intl_vld  (tx_intl_vld)
    );

    dlcr_lane_deser #(.DATA_W(DATA_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_pair (rx_fast_pair),
        .fast_vld  (rx_fast_vld),
        .intl_pair (rx_intl_pair),
        .intl_vld  (rx_intl_vld),
        .byte_out  (rx_byte),
        .byte_vld  (rx_byte_vld),
        .byte_path (rx_path)
    );

    // R6: with no byte on either path the block must be ready.
    a_r6_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_fast_vld && !tx_intl_vld) |-> tx_ready);

    // R1: a cycle in reset leaves every strobe low on the next cycle.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!tx_fast_vld && !tx_intl_vld && !rx_byte_vld));
endmodule

// File: tb/tb_dual_lane_chan_router.sv
module tb_dual_lane_chan_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_addr_sel = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       cfg_path = 1'b0;
    logic       tx_ready, tx_fast_vld, tx_intl_vld;
    logic [1:0] tx_fast_pair, tx_intl_pair;
    logic [1:0] d_fp = 2'b00, d_ip = 2'b00;
    logic       d_fv = 1'b0, d_iv = 1'b0, loop = 1'b0;
    logic [1:0] rx_fast_pair, rx_intl_pair;
    logic       rx_fast_vld, rx_intl_vld;
    logic [7:0] rx_byte;
    logic       rx_byte_vld, rx_path;

    int checks = 0, errors = 0, cycles = 0;
    string tag = "R1";

    assign rx_fast_pair = loop ? tx_fast_pair : d_fp;
    assign rx_fast_vld  = loop ? tx_fast_vld  : d_fv;
    assign rx_intl_pair = loop ? tx_intl_pair : d_ip;
    assign rx_intl_vld  = loop ? tx_intl_vld  : d_iv;

    dual_lane_chan_router dut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_addr_sel(tx_addr_sel), .cfg_mode(cfg_mode), .cfg_path(cfg_path),
        .tx_ready(tx_ready), .tx_fast_pair(tx_fast_pair), .tx_fast_vld(tx_fast_vld),
        .tx_intl_pair(tx_intl_pair), .tx_intl_vld(tx_intl_vld),
        .rx_fast_pair(rx_fast_pair), .rx_fast_vld(rx_fast_vld),
        .rx_intl_pair(rx_intl_pair), .rx_intl_vld(rx_intl_vld),
        .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld), .rx_path(rx_path)
    );

    always #10 clk = ~clk;

    // Snapshot of inputs and ready, taken mid-low-phase, used by the model.
    logic s_rst, s_val, s_sel, s_mode, s_cfg, s_ready, s_fv, s_iv;
    logic [7:0] s_data;
    logic [1:0] s_fp, s_ip;
    // Behavioural reference state.
    int  m_act = 0, m_cnt = 0, m_path = 0, r_cnt = 0, r_first = 0;
    int  e_vld = 0, e_path = 0, started = 0;
    logic [7:0] m_byte = 8'h00, r_acc = 8'h00, e_byte = 8'h00;

    always @(posedge clk) begin
        started = 1;
        if (!s_rst) begin
            m_act = 0; m_cnt = 0; r_cnt = 0; e_vld = 0;
        end else begin
            if ((m_act == 0 || m_cnt == 3) && s_val) begin
                m_act = 1; m_cnt = 0; m_byte = s_data;
                m_path = s_mode ? int'(s_cfg) : int'(s_sel);
            end else if (m_act != 0) begin
                if (m_cnt == 3) m_act = 0; else m_cnt = m_cnt + 1;
            end
            e_vld = 0;
            if (s_fv || s_iv) begin
                if (r_cnt == 0) r_first = s_fv ? 0 : 1;
                r_acc[2*r_cnt]   = s_fv ? s_fp[0] : s_ip[0];
                r_acc[2*r_cnt+1] = s_fv ? s_fp[1] : s_ip[1];
                if (r_cnt == 3) begin
                    e_vld = 1; e_byte = r_acc; e_path = r_first; r_cnt = 0;
                end else r_cnt = r_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at cycle %0d",
                     req, tag, what, act, exp, cycles);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        cycles++;
        if (started != 0) begin
            logic [1:0] ep;
            ep = (m_act != 0) ? {m_byte[2*m_cnt+1], m_byte[2*m_cnt]} : 2'b00;
            chk("R6", int'(tx_ready), (m_act == 0 || m_cnt == 3) ? 1 : 0, "tx_ready");
            chk("R5", int'(tx_fast_vld), (m_act != 0 && m_path == 0) ? 1 : 0, "fast_vld");
            chk("R5", int'(tx_intl_vld), (m_act != 0 && m_path == 1) ? 1 : 0, "intl_vld");
            chk("R2", int'(tx_fast_pair), (m_path == 0) ? int'(ep) : 0, "fast_pair");
            chk("R2", int'(tx_intl_pair), (m_path == 1) ? int'(ep) : 0, "intl_pair");
            chk("R7", int'(rx_byte_vld), e_vld, "rx_byte_vld");
            if (e_vld != 0) begin
                chk("R7", int'(rx_byte), int'(e_byte), "rx_byte");
                chk("R9", int'(rx_path), e_path, "rx_path");
            end
        end
        #5;
        s_rst = rst_n; s_val = tx_valid; s_sel = tx_addr_sel; s_mode = cfg_mode;
        s_cfg = cfg_path; s_data = tx_data; s_ready = tx_ready;
        s_fv = rx_fast_vld; s_iv = rx_intl_vld; s_fp = rx_fast_pair; s_ip = rx_intl_pair;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog (%s): actual hung expected done", tag);
        summary();
    end

    task automatic send(input logic [7:0] d, input logic sel);
        @(negedge clk); #1;
        tx_valid = 1'b1; tx_data = d; tx_addr_sel = sel;
        forever begin
            @(posedge clk);
            if (s_ready) break;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk); #1;
        tx_valid = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic rxp(input logic [1:0] fp, input logic fv, input logic [1:0] ip, input logic iv);
        @(negedge clk); #1;
        d_fp = fp; d_fv = fv; d_ip = ip; d_iv = iv;
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        chk("R1", int'(tx_fast_vld | tx_intl_vld | rx_byte_vld), 0, "strobes in reset");
        chk("R1", int'(tx_ready), 1, "ready in reset");
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(tx_fast_vld | tx_intl_vld | rx_byte_vld), 0, "strobes after reset");
        tag = "R2";
        send(8'hA5, 1'b0); idle(6);
        send(8'h5A, 1'b0); idle(6);
        tag = "R3";
        send(8'h3C, 1'b1); idle(6);
        cfg_mode = 1'b1; cfg_path = 1'b1;
        send(8'h96, 1'b0); idle(6);
        cfg_path = 1'b0;
        send(8'hE1, 1'b1); idle(6);
        tag = "R4";
        cfg_mode = 1'b0;
        send(8'hC3, 1'b0);
        @(negedge clk); #1 tx_valid = 1'b0; tx_addr_sel = 1'b1; cfg_mode = 1'b1; cfg_path = 1'b1;
        @(negedge clk); #1 tx_addr_sel = 1'b0; cfg_mode = 1'b0;
        idle(5);
        tag = "R6";
        cfg_mode = 1'b0;
        send(8'h11, 1'b0); send(8'h22, 1'b1); send(8'h4B, 1'b0); send(8'hF0, 1'b1);
        idle(6);
        tag = "R7";
        loop = 1'b1;
        send(8'h69, 1'b0); send(8'hD2, 1'b1); send(8'h07, 1'b1);
        idle(8);
        loop = 1'b0;
        tag = "R8";
        rxp(2'b01, 1'b1, 2'b10, 1'b1);
        rxp(2'b11, 1'b1, 2'b00, 1'b1);
        rxp(2'b00, 1'b1, 2'b11, 1'b1);
        rxp(2'b10, 1'b1, 2'b01, 1'b1);
        rxp(2'b00, 1'b0, 2'b00, 1'b0);
        repeat (3) @(negedge clk);
        tag = "R9";
        rxp(2'b00, 1'b0, 2'b10, 1'b1);
        rxp(2'b01, 1'b1, 2'b00, 1'b0);
        rxp(2'b11, 1'b1, 2'b00, 1'b0);
        rxp(2'b00, 1'b0, 2'b01, 1'b1);
        rxp(2'b00, 1'b0, 2'b00, 1'b0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule